// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This block sits between a processor core and a byte-addressed data memory with a 32-bit data path. For each access it adds the base register to the 16-bit signed displacement, decides the access width and extension from the operation code, and checks that the effective address fits that width. Correctly aligned accesses go straight to the memory port in the same cycle. Misaligned ones are held back, and a one-cycle fault flag is raised instead.

For stores, the block copies the source data into every lane that could be written and sets the byte enables to the lanes being written. For loads, it records which lanes the access needs. In the following cycle, when the synchronous memory returns the word, it picks out the byte or half-word and widens it with zeros or with copies of its top bit. The result comes out with a valid strobe.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. An accepted access drives `mem_addr` with that address and its two low bits cleared.
- R2: Op 0x03 loads the byte in lane `ea[1:0]` (lane 0 is bits 7:0, little-endian) and fills bits 31:8 with zeros.
- R3: Op 0x04 loads the byte in lane `ea[1:0]` and fills bits 31:8 with copies of the byte's bit 7.
- R4: Op 0x05 loads the half-word at byte offset `ea[1]*2` with zero fill. Op 0x06 loads the same half-word with the upper 16 bits copied from its bit 15.
- R5: Op 0x07 loads the whole 32-bit word unchanged.
- R6: Op 0x08 stores a byte. `mem_we`=1, `mem_be` = 4'b0001 << `ea[1:0]`, and `mem_wdata` holds `req_wdata[7:0]` in all four lanes.
- R7: Op 0x09 stores a half-word. `mem_be` = 4'b0011 << `ea[1:0]`, and `mem_wdata` holds `req_wdata[15:0]` in both halves.
- R8: Op 0x0A stores a word. `mem_be` = 4'b1111, and `mem_wdata` equals `req_wdata`.
- R9: A half-word access with `ea[0]`=1, or a word access with `ea[1:0]`≠0, drives `mem_req` low in its request cycle. It pulses `align_fault` high for exactly the next cycle and gives no load response. Byte accesses never fault.
- R10: A load response arrives one cycle after its request, with `rsp_valid` high for that single cycle. Stores produce no response.
- R11: Any other op code, or any cycle with `req_valid` low, produces no memory request, no fault and no response.
- R12: During and right after reset, `rsp_valid` and `align_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |
| align_fault | output | 1 | One-cycle misalignment pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 32-bit address, a 16-bit displacement and a sign-extended offset. These settings bring a negative displacement that wraps below the base within reach, along with all four byte lanes and both half-word positions. Requests are issued back to back, so a fault can directly follow a load and a load can directly follow a store to the same word. A rejected store is followed by a read-back of the word it would have written.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      is_mem;
      logic      is_store;
      logic      sext;
      acc_size_e size;
   } acc_ctrl_t;

   localparam logic [5:0] OP_LD_BYTE_U = 6'h03;
   localparam logic [5:0] OP_LD_BYTE_S = 6'h04;
   localparam logic [5:0] OP_LD_HALF_U = 6'h05;
   localparam logic [5:0] OP_LD_HALF_S = 6'h06;
   localparam logic [5:0] OP_LD_WORD   = 6'h07;
   localparam logic [5:0] OP_ST_BYTE   = 6'h08;
   localparam logic [5:0] OP_ST_HALF   = 6'h09;
   localparam logic [5:0] OP_ST_WORD   = 6'h0A;

   function automatic acc_ctrl_t decode_op(input logic [5:0] op);
      acc_ctrl_t c;
      c = '{is_mem: 1'b0, is_store: 1'b0, sext: 1'b0, size: SZ_WORD};
      unique case (op)
         OP_LD_BYTE_U: c = '{1'b1, 1'b0, 1'b0, SZ_BYTE};
         OP_LD_BYTE_S: c = '{1'b1, 1'b0, 1'b1, SZ_BYTE};
         OP_LD_HALF_U: c = '{1'b1, 1'b0, 1'b0, SZ_HALF};
         OP_LD_HALF_S: c = '{1'b1, 1'b0, 1'b1, SZ_HALF};
         OP_LD_WORD:   c = '{1'b1, 1'b0, 1'b0, SZ_WORD};
         OP_ST_BYTE:   c = '{1'b1, 1'b1, 1'b0, SZ_BYTE};
         OP_ST_HALF:   c = '{1'b1, 1'b1, 1'b0, SZ_HALF};
         OP_ST_WORD:   c = '{1'b1, 1'b1, 1'b0, SZ_WORD};
         default:      c = '{1'b0, 1'b0, 1'b0, SZ_WORD};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int LANE_W   = 2,
   parameter bit SEXT_OFF = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   input  acc_size_e         size,
   output logic [ADDR_W-1:0] ea,
   output logic              misaligned
);
   localparam int PAD_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;

   generate
      if (SEXT_OFF) begin : g_sext
         assign off_ext = {{PAD_W{offset[OFF_W-1]}}, offset};
      end else begin : g_zext
         assign off_ext = {{PAD_W{1'b0}}, offset};
      end
   endgenerate

   assign ea = base + off_ext;

   always_comb begin
      unique case (size)
         SZ_HALF: misaligned = ea[0];
         SZ_WORD: misaligned = |ea[LANE_W-1:0];
         default: misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic [DATA_W-1:0]   src,
   input  acc_size_e           size,
   input  logic [LANE_W-1:0]   lane,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   data
);
   localparam int NLANES = DATA_W / 8;
   localparam int NHALF  = NLANES / 2;

   logic [DATA_W-1:0] rep_byte;
   logic [DATA_W-1:0] rep_half;

   genvar g;
   generate
      for (g = 0; g < NLANES; g++) begin : g_byte_rep
         assign rep_byte[g*8 +: 8] = src[7:0];
      end
      for (g = 0; g < NHALF; g++) begin : g_half_rep
         assign rep_half[g*16 +: 16] = src[15:0];
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            be   = {{(NLANES-1){1'b0}}, 1'b1} << lane;
            data = rep_byte;
         end
         SZ_HALF: begin
            be   = {{(NLANES-2){1'b0}}, 2'b11} << lane;
            data = rep_half;
         end
         default: begin
            be   = '1;
            data = src;
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic [DATA_W-1:0] word,
   input  acc_size_e         size,
   input  logic              sext,
   input  logic [LANE_W-1:0] lane,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] shifted;
   logic              fill;

   assign shifted = word >> {lane, 3'b000};

   always_comb begin
      fill = 1'b0;
      unique case (size)
         SZ_BYTE: begin
            fill   = sext & shifted[7];
            result = {{(DATA_W-8){fill}}, shifted[7:0]};
         end
         SZ_HALF: begin
            fill   = sext & shifted[15];
            result = {{(DATA_W-16){fill}}, shifted[15:0]};
         end
         default: result = word;
      endcase
   end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 16,
   parameter bit SEXT_OFF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [5:0]          req_op,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [OFF_W-1:0]    req_offset,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   output logic                align_fault
);
   localparam int NLANES = DATA_W / 8;
   localparam int LANE_W = $clog2(NLANES);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("lsu_align_unit: DATA_W must be 32");
      end
      if (OFF_W >= ADDR_W || OFF_W < 2) begin : g_bad_off_w
         $error("lsu_align_unit: OFF_W must lie in [2, ADDR_W)");
      end
   endgenerate

   acc_ctrl_t         ctrl;
   logic [ADDR_W-1:0] ea;
   logic              misaligned;
   logic              take;

   logic              pend_load;
   acc_size_e         pend_size;
   logic              pend_sext;
   logic [LANE_W-1:0] pend_lane;
   logic              fault_q;

   assign ctrl = decode_op(req_op);
   assign take = req_valid & ctrl.is_mem;

   lsu_agen #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W), .SEXT_OFF(SEXT_OFF)
   ) u_agen (
      .base(req_base), .offset(req_offset), .size(ctrl.size),
      .ea(ea), .misaligned(misaligned)
   );

   lsu_store_lanes #(
      .DATA_W(DATA_W), .LANE_W(LANE_W)
   ) u_store (
      .src(req_wdata), .size(ctrl.size), .lane(ea[LANE_W-1:0]),
      .be(mem_be), .data(mem_wdata)
   );

   assign mem_req  = take & ~misaligned;
   assign mem_we   = ctrl.is_store;
   assign mem_addr = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_load <= 1'b0;
         pend_size <= SZ_WORD;
         pend_sext <= 1'b0;
         pend_lane <= '0;
         fault_q   <= 1'b0;
      end else begin
         pend_load <= mem_req & ~ctrl.is_store;
         fault_q   <= take & misaligned;
         if (mem_req & ~ctrl.is_store) begin
            pend_size <= ctrl.size;
            pend_sext <= ctrl.sext;
            pend_lane <= ea[LANE_W-1:0];
         end
      end
   end

   lsu_load_extract #(
      .DATA_W(DATA_W), .LANE_W(LANE_W)
   ) u_load (
      .word(mem_rdata), .size(pend_size), .sext(pend_sext),
      .lane(pend_lane), .result(rsp_data)
   );

   assign rsp_valid   = pend_load;
   assign align_fault = fault_q;
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [5:0]          req_op,
   input logic                mem_req,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic                rsp_valid,
   input logic                align_fault
);
   assert_word_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && req_op == 6'h08) |-> ($countones(mem_be) == 1 && mem_we));

   assert_half_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && req_op == 6'h09) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

   assert_word_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && req_op == 6'h0A) |-> (mem_be == 4'b1111));

   assert_fault_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> ($past(req_valid) && !$past(mem_req)));

   assert_fault_excl_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(align_fault && rsp_valid));

   assert_rsp_after_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(mem_req) && !$past(mem_we)));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !mem_req);
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsu_align_unit_bench.sv
module lsu_align_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_op = '0;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        align_fault;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct {
      int          due;
      int          kind;   // 0 none, 1 load, 2 fault
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   logic [31:0] mem_arr [16];
   logic [31:0] ref_mem [16];

   always #2 clk = ~clk;

   lsu_align_unit u_lsu_align_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .align_fault(align_fault)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem_arr[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         end else begin
            mem_rdata <= mem_arr[mem_addr[5:2]];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t it;
            it = exp_q.pop_front();
            chk({it.tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, it.kind == 1});
            chk({it.tag, " align_fault"}, {31'd0, align_fault}, {31'd0, it.kind == 2});
            if (it.kind == 1) chk({it.tag, " rsp_data"}, rsp_data, it.data);
         end else if (rsp_valid || align_fault) begin
            chk("R11 unexpected output", {30'd0, rsp_valid, align_fault}, 32'd0);
         end
      end
   end

   task automatic issue(input logic valid, input logic [5:0] op, input logic [31:0] base,
                        input logic [15:0] off, input logic [31:0] wd, input string tag);
      logic [31:0] ea, w, sh, expd, wexp;
      logic [3:0]  be;
      int sz;
      bit ld, st, sg, mis;
      exp_t it;
      ea = base + {{16{off[15]}}, off};
      ld = 0; st = 0; sg = 0; sz = 0;
      case (op)
         6'h03: begin ld = 1; sz = 1; end
         6'h04: begin ld = 1; sz = 1; sg = 1; end
         6'h05: begin ld = 1; sz = 2; end
         6'h06: begin ld = 1; sz = 2; sg = 1; end
         6'h07: begin ld = 1; sz = 4; end
         6'h08: begin st = 1; sz = 1; end
         6'h09: begin st = 1; sz = 2; end
         6'h0A: begin st = 1; sz = 4; end
         default: ;
      endcase
      if (!valid) begin ld = 0; st = 0; end
      mis = (sz == 2 && ea[0]) || (sz == 4 && ea[1:0] != 2'b00);
      expd = '0;
      if (ld && !mis) begin
         w  = ref_mem[ea[5:2]];
         sh = w >> (ea[1:0] * 8);
         if (sz == 1)      expd = sg ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
         else if (sz == 2) expd = sg ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]};
         else              expd = w;
      end
      @(negedge clk);
      req_valid = valid; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
      it.due = cyc + 1;
      it.kind = ((ld || st) && mis) ? 2 : (ld ? 1 : 0);
      it.data = expd;
      it.tag = tag;
      exp_q.push_back(it);
      #1;
      if (!(ld || st) || mis) begin
         chk({tag, " mem_req low"}, {31'd0, mem_req}, 32'd0);
      end else begin
         chk({tag, " R1 mem_addr"}, mem_addr, {ea[31:2], 2'b00});
         chk({tag, " mem_req/we"}, {30'd0, mem_req, mem_we}, {30'd0, 1'b1, st});
         if (st) begin
            if (sz == 1)      begin be = 4'b0001 << ea[1:0]; wexp = {4{wd[7:0]}}; end
            else if (sz == 2) begin be = 4'b0011 << ea[1:0]; wexp = {2{wd[15:0]}}; end
            else              begin be = 4'b1111;            wexp = wd; end
            chk({tag, " mem_be"}, {28'd0, mem_be}, {28'd0, be});
            chk({tag, " mem_wdata"}, mem_wdata, wexp);
            for (int b = 0; b < 4; b++)
               if (be[b]) ref_mem[ea[5:2]][b*8 +: 8] = wexp[b*8 +: 8];
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin mem_arr[i] = '0; ref_mem[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R12 reset align_fault", {31'd0, align_fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 after reset quiet", {30'd0, rsp_valid, align_fault}, 32'd0);

      issue(1, 6'h0A, 32'h40, 16'hFFE0, 32'h11223344, "R8 STW neg off R1");
      issue(1, 6'h0A, 32'h10, 16'h0014, 32'h8899AABB, "R8 STW pos off");
      issue(1, 6'h08, 32'h21, 16'h0000, 32'h000000A5, "R6 STB lane1");
      issue(1, 6'h09, 32'h20, 16'h0006, 32'h0000F00D, "R7 STH upper");
      issue(1, 6'h07, 32'h20, 16'h0000, 32'h0, "R5 LDW");
      issue(1, 6'h03, 32'h22, 16'hFFFF, 32'h0, "R2 LDB lane1");
      issue(1, 6'h04, 32'h21, 16'h0000, 32'h0, "R3 LDBS neg");
      issue(1, 6'h03, 32'h20, 16'h0000, 32'h0, "R2 LDB lane0");
      issue(1, 6'h04, 32'h23, 16'h0000, 32'h0, "R3 LDBS pos lane3");
      issue(1, 6'h05, 32'h26, 16'h0000, 32'h0, "R4 LDH upper");
      issue(1, 6'h06, 32'h26, 16'h0000, 32'h0, "R4 LDHS upper");
      issue(1, 6'h06, 32'h24, 16'h0000, 32'h0, "R4 LDHS lower");
      issue(1, 6'h05, 32'h22, 16'h0000, 32'h0, "R4 LDH lane2");
      issue(1, 6'h05, 32'h23, 16'h0000, 32'h0, "R9 LDH odd");
      issue(1, 6'h07, 32'h22, 16'h0000, 32'h0, "R9 LDW half-aligned");
      issue(1, 6'h0A, 32'h21, 16'h0000, 32'hDEADBEEF, "R9 STW misaligned");
      issue(1, 6'h09, 32'h25, 16'h0000, 32'hCAFE, "R9 STH odd");
      issue(1, 6'h07, 32'h20, 16'h0000, 32'h0, "R9 word unchanged after rejected store");
      issue(1, 6'h07, 32'h24, 16'h0000, 32'h0, "R10 LDW back to back");
      issue(1, 6'h08, 32'h27, 16'h0000, 32'h0000005A, "R6 STB lane3");
      issue(1, 6'h03, 32'h27, 16'h0000, 32'h0, "R10 load right after store");
      issue(1, 6'h19, 32'h20, 16'h0000, 32'h0, "R11 other op");
      issue(0, 6'h07, 32'h22, 16'h0000, 32'h0, "R11 valid low");
      issue(1, 6'h03, 32'h23, 16'h0000, 32'h0, "R9 byte never faults");
      issue(0, 6'h00, 32'h0, 16'h0, 32'h0, "R10 idle");
      issue(0, 6'h00, 32'h0, 16'h0, 32'h0, "R10 idle");
      @(negedge clk);
      @(negedge clk);
      if (exp_q.size() != 0) chk("R10 pending responses", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule